// File: doc/BRIEF.md
# Processor Mailbox Doorbell Controller

This block carries doorbell signals between a host CPU and a power-management coprocessor over eight independent channels. Each direction has its own bit set. The host rings a request doorbell by writing ones to a set register. The pending request bits can be read back and are also brought out to the coprocessor. The coprocessor drops a request bit with a per-channel clear strobe once it has consumed that request. It answers by raising a per-channel acknowledge bit, and that bit drives the host interrupt until the host clears it through a write-one-to-clear register.

Each channel also owns two header bytes in a small shared window. The host writes the request header and the coprocessor reads it. The coprocessor writes the acknowledge header and the host reads it. The host writes any payload and then the header, and rings the doorbell last. The host must not post on a channel while that channel's request bit still reads one.

The register interface is a byte-wide synchronous bus. Read data is registered, so it appears one cycle after the address is presented.

Top module: `doorbell_mbox`

## Requirements
- R1: After reset, the request bits, the acknowledge bits, every header byte, the read data and the interrupt are all zero.
- R2: A write to address 0x10 sets request bit n for every bit n of the write data that is one, and leaves bits written as zero unchanged. The request bits read back at both 0x10 and 0x11 and appear on `req_pending`.
- R3: A high `cop_req_clr[n]` clears request bit n at the next edge. When a host set and a coprocessor clear reach the same bit in one cycle, the bit ends up set.
- R4: A high `cop_ack_set[n]` sets acknowledge bit n, which reads back at 0x12. A write to 0x13 clears each acknowledge bit written as one and leaves bits written as zero unchanged. A coprocessor set wins over a host clear of the same bit in the same cycle.
- R5: `irq` is high exactly while at least one acknowledge bit is set. It stays high until the last set bit is cleared.
- R6: Address 0x00+n is channel n's request header byte, which the host can read and write. The coprocessor reads it combinationally on `cop_req_hdr_data` by selecting n on `cop_req_hdr_ch`.
- R7: Address 0x08+n is channel n's acknowledge header byte. Only the coprocessor's header write port can change it. A host bus write to that address has no effect, and the host reads the byte back there.
- R8: A single write of 0xFF to 0x13 clears all eight acknowledge bits at once and drops `irq`.
- R9: Read data is registered, so `bus_rdata` shows the addressed value one cycle after `bus_addr`. Addresses 0x14 to 0x1F read as zero, 0x13 reads as zero, and host writes to 0x11 and 0x12 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_addr | input | 5 | Host register byte address |
| bus_we | input | 1 | Host write enable |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Host read data, one cycle after the address |
| cop_req_clr | input | 8 | Coprocessor per-channel request clear strobes |
| cop_ack_set | input | 8 | Coprocessor per-channel acknowledge set strobes |
| cop_ack_hdr_we | input | 1 | Coprocessor acknowledge header write enable |
| cop_ack_hdr_ch | input | 3 | Channel of the acknowledge header write |
| cop_ack_hdr_data | input | 8 | Acknowledge header write data |
| cop_req_hdr_ch | input | 3 | Channel whose request header the coprocessor reads |
| cop_req_hdr_data | output | 8 | Selected request header byte |
| req_pending | output | 8 | Pending request doorbell bits |
| irq | output | 1 | Host interrupt, OR of the acknowledge bits |

## Verification
The assertions assume that the strobe inputs are synchronous to `clk` and that each asserted strobe bit means exactly one event. They also assume that an interrupt can only rise after a coprocessor acknowledge set in the cycle before. The stimulus drives every input at the falling edge and holds strobes for exactly one cycle. Simultaneous set and clear cases are applied on purpose so that the set-wins priority is exercised. The host never writes a request header while the coprocessor selects it, so combinational header reads see only settled values.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int unsigned MB_CH  = 8;
  localparam int unsigned MB_DW  = 8;
  localparam int unsigned MB_AW  = 5;
  localparam int unsigned MB_CHW = $clog2(MB_CH);

  typedef logic [MB_AW-1:0] addr_t;
  typedef logic [MB_DW-1:0] byte_t;
  typedef logic [MB_CH-1:0] chmask_t;

  // register window: headers first, then the doorbell registers
  localparam addr_t A_ACK_HDR = MB_AW'(MB_CH);
  localparam addr_t A_REQ_SET = MB_AW'(2 * MB_CH);
  localparam addr_t A_REQ_VAL = MB_AW'(2 * MB_CH + 1);
  localparam addr_t A_ACK_VAL = MB_AW'(2 * MB_CH + 2);
  localparam addr_t A_ACK_CLR = MB_AW'(2 * MB_CH + 3);
endpackage

// File: rtl/mbox_rst_sync.sv
module mbox_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/mbox_bitbank.sv
module mbox_bitbank #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] set_i,
  input  logic [WIDTH-1:0] clr_i,
  output logic [WIDTH-1:0] bits_o
);
  logic [WIDTH-1:0] bits_q;
  logic [WIDTH-1:0] bits_d;
  logic             upd;

  // a set arriving with a clear of the same bit leaves the bit set
  always_comb begin
    bits_d = (bits_q & ~clr_i) | set_i;
    upd    = |(set_i | clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   bits_q <= '0;
    else if (upd) bits_q <= bits_d;
  end

  assign bits_o = bits_q;

  for (genvar i = 0; i < WIDTH; i++) begin : g_chk
    a_r3_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[i] |=> bits_o[i]);
    a_r3_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[i] && !set_i[i]) |=> !bits_o[i]);
    a_r2_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i[i] && !set_i[i]) |=> $stable(bits_o[i]));
  end
endmodule

// File: rtl/mbox_hdr_store.sv
module mbox_hdr_store
  import mbox_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  chmask_t             host_we_i,
  input  byte_t               host_wdata_i,
  input  logic                cop_we_i,
  input  logic [MB_CHW-1:0]   cop_ch_i,
  input  byte_t               cop_wdata_i,
  output byte_t               req_hdr_o [MB_CH],
  output byte_t               ack_hdr_o [MB_CH]
);
  for (genvar j = 0; j < MB_CH; j++) begin : g_ch
    byte_t req_q, ack_q;
    logic  ack_en;

    always_comb ack_en = cop_we_i && (cop_ch_i == MB_CHW'(j));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            req_q <= '0;
      else if (host_we_i[j]) req_q <= host_wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ack_q <= '0;
      else if (ack_en) ack_q <= cop_wdata_i;
    end

    assign req_hdr_o[j] = req_q;
    assign ack_hdr_o[j] = ack_q;

    // R7: only the coprocessor port may change an acknowledge header
    a_r7_ack_hdr_owner: assert property (@(posedge clk) disable iff (!rst_n)
      !(cop_we_i && cop_ch_i == MB_CHW'(j)) |=> $stable(ack_hdr_o[j]));
  end
endmodule

// File: rtl/mbox_regif.sv
module mbox_regif
  import mbox_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  addr_t   addr_i,
  input  logic    we_i,
  input  byte_t   wdata_i,
  output byte_t   rdata_o,
  input  chmask_t req_bits_i,
  input  chmask_t ack_bits_i,
  input  byte_t   req_hdr_i [MB_CH],
  input  byte_t   ack_hdr_i [MB_CH],
  output chmask_t host_set_o,
  output chmask_t host_clr_o,
  output chmask_t req_hdr_we_o
);
  logic [MB_CHW-1:0] idx;
  byte_t             rd_d, rd_q;

  assign idx = addr_i[MB_CHW-1:0];

  always_comb begin
    host_set_o = (we_i && addr_i == A_REQ_SET) ? wdata_i[MB_CH-1:0] : '0;
    host_clr_o = (we_i && addr_i == A_ACK_CLR) ? wdata_i[MB_CH-1:0] : '0;
  end

  for (genvar j = 0; j < MB_CH; j++) begin : g_hwe
    assign req_hdr_we_o[j] = we_i && (addr_i == MB_AW'(j));
  end

  always_comb begin
    rd_d = '0;
    if (addr_i < A_ACK_HDR)      rd_d = req_hdr_i[idx];
    else if (addr_i < A_REQ_SET) rd_d = ack_hdr_i[idx];
    else begin
      case (addr_i)
        A_REQ_SET, A_REQ_VAL: rd_d = MB_DW'(req_bits_i);
        A_ACK_VAL:            rd_d = MB_DW'(ack_bits_i);
        default:              rd_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= '0;
    else        rd_q <= rd_d;
  end

  assign rdata_o = rd_q;

  a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_i > A_ACK_VAL) |=> (rdata_o == '0));
  a_r9_ackval_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_i == A_ACK_VAL) |=> (rdata_o == MB_DW'($past(ack_bits_i))));
endmodule

// File: rtl/doorbell_mbox.sv
module doorbell_mbox
  import mbox_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MB_AW-1:0]  bus_addr,
  input  logic              bus_we,
  input  logic [MB_DW-1:0]  bus_wdata,
  output logic [MB_DW-1:0]  bus_rdata,
  input  logic [MB_CH-1:0]  cop_req_clr,
  input  logic [MB_CH-1:0]  cop_ack_set,
  input  logic              cop_ack_hdr_we,
  input  logic [MB_CHW-1:0] cop_ack_hdr_ch,
  input  logic [MB_DW-1:0]  cop_ack_hdr_data,
  input  logic [MB_CHW-1:0] cop_req_hdr_ch,
  output logic [MB_DW-1:0]  cop_req_hdr_data,
  output logic [MB_CH-1:0]  req_pending,
  output logic              irq
);
  logic    rst_sync_n;
  chmask_t req_bits, ack_bits, host_set, host_clr, hdr_we;
  byte_t   req_hdr [MB_CH];
  byte_t   ack_hdr [MB_CH];

  mbox_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  mbox_bitbank #(.WIDTH(MB_CH)) u_req (
    .clk(clk), .rst_n(rst_sync_n),
    .set_i(host_set), .clr_i(cop_req_clr), .bits_o(req_bits));

  mbox_bitbank #(.WIDTH(MB_CH)) u_ack (
    .clk(clk), .rst_n(rst_sync_n),
    .set_i(cop_ack_set), .clr_i(host_clr), .bits_o(ack_bits));

  mbox_hdr_store u_hdr (
    .clk(clk), .rst_n(rst_sync_n),
    .host_we_i(hdr_we), .host_wdata_i(bus_wdata),
    .cop_we_i(cop_ack_hdr_we), .cop_ch_i(cop_ack_hdr_ch),
    .cop_wdata_i(cop_ack_hdr_data),
    .req_hdr_o(req_hdr), .ack_hdr_o(ack_hdr));

  mbox_regif u_reg (
    .clk(clk), .rst_n(rst_sync_n),
    .addr_i(bus_addr), .we_i(bus_we), .wdata_i(bus_wdata),
    .rdata_o(bus_rdata),
    .req_bits_i(req_bits), .ack_bits_i(ack_bits),
    .req_hdr_i(req_hdr), .ack_hdr_i(ack_hdr),
    .host_set_o(host_set), .host_clr_o(host_clr), .req_hdr_we_o(hdr_we));

  assign cop_req_hdr_data = req_hdr[cop_req_hdr_ch];
  assign req_pending      = req_bits;
  assign irq              = |ack_bits;

  // R5: the interrupt can only rise after a coprocessor acknowledge
  a_r5_irq_rise: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(irq) |-> ($past(cop_ack_set) != '0));
  // R8: clearing every bit with no new set drops the interrupt
  a_r8_clear_all: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_we && bus_addr == A_ACK_CLR && bus_wdata == 8'hFF && cop_ack_set == '0)
      |=> !irq);
endmodule

// File: tb/sim_doorbell_mbox.sv
`timescale 1ns/1ps
module sim_doorbell_mbox;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [4:0] bus_addr;
  logic       bus_we;
  logic [7:0] bus_wdata, bus_rdata;
  logic [7:0] cop_req_clr, cop_ack_set;
  logic       cop_ack_hdr_we;
  logic [2:0] cop_ack_hdr_ch, cop_req_hdr_ch;
  logic [7:0] cop_ack_hdr_data, cop_req_hdr_data, req_pending;
  logic       irq;

  always #2 clk = ~clk;

  doorbell_mbox u0 (.*);

  int cyc = 0;
  int n_cmp = 0;
  int n_bad = 0;
  logic [7:0] q_exp[$];
  int         q_due[$];
  string      q_tag[$];

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compare registered read data in the cycle it is due
  always @(negedge clk) begin
    if (q_due.size() > 0 && q_due[0] == cyc) begin
      n_cmp++;
      if (bus_rdata !== q_exp[0]) begin
        n_bad++;
        $display("FAIL %s: rdata=%h expected=%h", q_tag[0], bus_rdata, q_exp[0]);
      end
      void'(q_exp.pop_front());
      void'(q_due.pop_front());
      void'(q_tag.pop_front());
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_rd(input logic [4:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    q_exp.push_back(exp);
    q_due.push_back(cyc + 1);
    q_tag.push_back(tag);
  endtask

  task automatic cop_strobe(input logic [7:0] clr, input logic [7:0] set);
    @(negedge clk);
    cop_req_clr = clr; cop_ack_set = set;
    @(negedge clk);
    cop_req_clr = '0; cop_ack_set = '0;
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0;
    cop_req_clr = '0; cop_ack_set = '0; cop_ack_hdr_we = 1'b0;
    cop_ack_hdr_ch = '0; cop_ack_hdr_data = '0; cop_req_hdr_ch = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 irq", {7'd0, irq}, 8'h00);
    chk("R1 req_pending", req_pending, 8'h00);
    bus_rd(5'h10, 8'h00, "R1 req bits");
    bus_rd(5'h12, 8'h00, "R1 ack bits");
    bus_rd(5'h00, 8'h00, "R1 req hdr");
    bus_rd(5'h0F, 8'h00, "R1 ack hdr");

    // R2 write-one-to-set
    bus_wr(5'h10, 8'hA5);
    chk("R2 req_pending", req_pending, 8'hA5);
    bus_rd(5'h10, 8'hA5, "R2 set readback");
    bus_rd(5'h11, 8'hA5, "R2 value readback");
    bus_wr(5'h10, 8'h00);
    bus_rd(5'h11, 8'hA5, "R2 zeros ignored");
    bus_wr(5'h10, 8'h0A);
    bus_rd(5'h11, 8'hAF, "R2 accumulate");

    // R3 coprocessor clear and set-wins
    cop_strobe(8'h21, 8'h00);
    chk("R3 clear", req_pending, 8'h8E);
    @(negedge clk);
    bus_addr = 5'h10; bus_we = 1'b1; bus_wdata = 8'h01; cop_req_clr = 8'h03;
    @(negedge clk);
    bus_we = 1'b0; cop_req_clr = '0;
    chk("R3 set wins", req_pending, 8'h8D);
    bus_rd(5'h11, 8'h8D, "R3 readback");

    // R4 / R5 acknowledge bits and interrupt
    cop_strobe(8'h00, 8'h12);
    chk("R5 irq up", {7'd0, irq}, 8'h01);
    bus_rd(5'h12, 8'h12, "R4 ack set");
    bus_wr(5'h13, 8'h02);
    chk("R5 irq held", {7'd0, irq}, 8'h01);
    bus_rd(5'h12, 8'h10, "R4 w1c");
    bus_wr(5'h13, 8'h00);
    bus_rd(5'h12, 8'h10, "R4 zeros ignored");
    @(negedge clk);
    bus_addr = 5'h13; bus_we = 1'b1; bus_wdata = 8'h50; cop_ack_set = 8'h40;
    @(negedge clk);
    bus_we = 1'b0; cop_ack_set = '0;
    bus_rd(5'h12, 8'h40, "R4 set wins");
    bus_wr(5'h13, 8'h40);
    chk("R5 irq down", {7'd0, irq}, 8'h00);

    // R8 clear all in one write
    cop_strobe(8'h00, 8'hFF);
    bus_rd(5'h12, 8'hFF, "R8 all set");
    bus_wr(5'h13, 8'hFF);
    chk("R8 irq", {7'd0, irq}, 8'h00);
    bus_rd(5'h12, 8'h00, "R8 all clear");

    // R6 request headers
    bus_wr(5'h03, 8'h3C);
    bus_wr(5'h07, 8'hC3);
    bus_rd(5'h03, 8'h3C, "R6 hdr3");
    bus_rd(5'h07, 8'hC3, "R6 hdr7");
    @(negedge clk);
    cop_req_hdr_ch = 3'd3; #1;
    chk("R6 cop read 3", cop_req_hdr_data, 8'h3C);
    cop_req_hdr_ch = 3'd7; #1;
    chk("R6 cop read 7", cop_req_hdr_data, 8'hC3);

    // R7 acknowledge headers
    @(negedge clk);
    cop_ack_hdr_we = 1'b1; cop_ack_hdr_ch = 3'd5; cop_ack_hdr_data = 8'h5A;
    @(negedge clk);
    cop_ack_hdr_we = 1'b0;
    bus_rd(5'h0D, 8'h5A, "R7 ack hdr");
    bus_wr(5'h0D, 8'hFF);
    bus_rd(5'h0D, 8'h5A, "R7 host write ignored");

    // R9 map edges
    bus_rd(5'h1F, 8'h00, "R9 unmapped");
    bus_rd(5'h13, 8'h00, "R9 clear reg reads zero");
    bus_wr(5'h11, 8'hFF);
    bus_rd(5'h11, 8'h8D, "R9 value reg read-only");
    bus_wr(5'h12, 8'hFF);
    bus_rd(5'h12, 8'h00, "R9 ack value read-only");

    repeat (4) @(negedge clk);
    summary();
    $finish;
  end
endmodule